// File: doc/BRIEF.md
# Interval Timer with Split Period and Snapshot Registers

The block is a down-counting interval timer that software drives over a simple word-addressed register bus. Software writes a reload period as two half-width halves. It then sets the timer running or halts it by writing command bits to the control register. While the timer runs, the counter steps down by one on every clock. When the counter is at zero it expires. On expiry it raises a sticky timeout flag and then either reloads and keeps going (continuous mode) or halts (one-shot mode).

The timeout flag can drive an interrupt request. The request stays high until software writes anything to the status register. To read a live count without tearing, software first writes the low snapshot register. That write freezes the full count into the snapshot registers, and the two halves are then read at leisure. When the period is all ones, the elapsed time is the bitwise complement of the frozen count.

Top module: `interval_timer`

## Requirements
- R1: Word offsets decode as 0 status, 1 control, 2 period low half, 3 period high half, 4 snapshot low half, 5 snapshot high half. Period registers read back the last written value in bits HALF_W-1:0. Control reads back the interrupt-enable bit in bit 0 and the continuous bit in bit 1. Every other read bit, and offsets 6 and 7, read as zero.
- R2: While running, the counter decreases by one per clock. A running counter at zero expires on the next clock edge and sets the timeout flag (status bit 0). With period P written while stopped, the timeout flag reads 1 exactly P+1 clocks after the start write.
- R3: With control bit 1 set, expiry reloads the counter from the period and the timer stays running (status bit 1 stays 1).
- R4: With control bit 1 clear, expiry reloads the counter from the period and clears the running bit.
- R5: Control bit 2 (start) and bit 3 (stop) act only in the write cycle and read back as zero. Stop wins when both are set. A start while running does not reload the counter.
- R6: Any write to the status register clears the timeout flag, whatever the data. An expiry in the same cycle keeps the flag set.
- R7: irq_o is high exactly when the timeout flag and the interrupt-enable bit are both 1.
- R8: Any write to the snapshot low offset copies the whole live count into the snapshot registers. The snapshot then holds that value, and writes to the snapshot high offset leave it unchanged.
- R9: Writing a period half while stopped also loads the counter with the new full period. Writing a period half while running leaves the current count alone until the next reload.
- R10: After reset the counter, period, snapshot, control bits and status bits are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe, one write per clock |
| addr_i | input | ADDR_W | Word offset of the register accessed |
| wdata_i | input | BUS_W | Write data |
| rdata_o | output | BUS_W | Read data for addr_i, combinational |
| irq_o | output | 1 | Timeout interrupt request |

## Verification
The bench builds the timer with HALF_W of 8 and BUS_W of 16, which gives a 16-bit counter. Short periods then give many expiries in a short run, and a high half of 1 still lets a period carry across the two halves. At that size, random writes often land in the same cycle as an expiry: a status clear, a period write or a start command against a counter reaching zero. These collisions test the priority rules of R5, R6 and R9. Directed sequences pin down the P+1 expiry latency, stop-over-start priority and snapshot consistency.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int unsigned OFS_STATUS  = 0;
  localparam int unsigned OFS_CTRL    = 1;
  localparam int unsigned OFS_PER_LO  = 2;
  localparam int unsigned OFS_PER_HI  = 3;
  localparam int unsigned OFS_SNAP_LO = 4;
  localparam int unsigned OFS_SNAP_HI = 5;

  localparam int unsigned ST_TIMEOUT = 0;
  localparam int unsigned ST_RUN     = 1;

  localparam int unsigned CT_IEN   = 0;
  localparam int unsigned CT_CONT  = 1;
  localparam int unsigned CT_START = 2;
  localparam int unsigned CT_STOP  = 3;

  typedef struct packed {
    logic cont;
    logic ien;
  } ctrl_t;
endpackage

// File: rtl/itmr_regfile.sv
module itmr_regfile
  import itmr_pkg::*;
#(
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned HALF_W = 16,
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned CNT_W = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic              run_i,
  input  logic              timeout_i,
  input  logic [CNT_W-1:0]  snap_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  per_o,
  output logic [CNT_W-1:0]  per_next_o,
  output logic              per_wr_o,
  output logic              start_o,
  output logic              stop_o,
  output logic              clr_o,
  output logic              cap_o
);
  logic sel_status, sel_ctrl, sel_lo, sel_hi, sel_snap;
  ctrl_t ctrl_q;
  logic [CNT_W-1:0] per_q, per_d;
  logic unused_wdata;

  assign unused_wdata = ^wdata_i[BUS_W-1:HALF_W];

  assign sel_status = wr_en_i && (addr_i == ADDR_W'(OFS_STATUS));
  assign sel_ctrl   = wr_en_i && (addr_i == ADDR_W'(OFS_CTRL));
  assign sel_lo     = wr_en_i && (addr_i == ADDR_W'(OFS_PER_LO));
  assign sel_hi     = wr_en_i && (addr_i == ADDR_W'(OFS_PER_HI));
  assign sel_snap   = wr_en_i && (addr_i == ADDR_W'(OFS_SNAP_LO));

  always_comb begin
    per_d = per_q;
    if (sel_lo) per_d[HALF_W-1:0]     = wdata_i[HALF_W-1:0];
    if (sel_hi) per_d[CNT_W-1:HALF_W] = wdata_i[HALF_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q  <= '0;
      ctrl_q <= '0;
    end else begin
      per_q <= per_d;
      if (sel_ctrl) begin
        ctrl_q.ien  <= wdata_i[CT_IEN];
        ctrl_q.cont <= wdata_i[CT_CONT];
      end
    end
  end

  assign ctrl_o     = ctrl_q;
  assign per_o      = per_q;
  assign per_next_o = per_d;
  assign per_wr_o   = sel_lo || sel_hi;
  assign start_o    = sel_ctrl && wdata_i[CT_START];
  assign stop_o     = sel_ctrl && wdata_i[CT_STOP];
  assign clr_o      = sel_status;
  assign cap_o      = sel_snap;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(OFS_STATUS): begin
        rdata_o[ST_TIMEOUT] = timeout_i;
        rdata_o[ST_RUN]     = run_i;
      end
      ADDR_W'(OFS_CTRL): begin
        rdata_o[CT_IEN]  = ctrl_q.ien;
        rdata_o[CT_CONT] = ctrl_q.cont;
      end
      ADDR_W'(OFS_PER_LO):  rdata_o[HALF_W-1:0] = per_q[HALF_W-1:0];
      ADDR_W'(OFS_PER_HI):  rdata_o[HALF_W-1:0] = per_q[CNT_W-1:HALF_W];
      ADDR_W'(OFS_SNAP_LO): rdata_o[HALF_W-1:0] = snap_i[HALF_W-1:0];
      ADDR_W'(OFS_SNAP_HI): rdata_o[HALF_W-1:0] = snap_i[CNT_W-1:HALF_W];
      default: rdata_o = '0;
    endcase
  end

  AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_ctrl |=> $stable(ctrl_q)) else $error("control changed without write"); // R1
  AST_PER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_lo || sel_hi) |=> $stable(per_q)) else $error("period changed without write"); // R1
endmodule

// File: rtl/itmr_core.sv
module itmr_core #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cont_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output logic             timeout_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic run_q, to_q, expire;

  assign expire = run_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      to_q  <= 1'b0;
    end else begin
      if (run_q)       cnt_q <= expire ? reload_val_i : cnt_q - ONE;
      else if (load_i) cnt_q <= load_val_i;
      // command write beats expiry for the running bit; stop beats start
      if (stop_i)                 run_q <= 1'b0;
      else if (start_i)           run_q <= 1'b1;
      else if (expire && !cont_i) run_q <= 1'b0;
      // new expiry beats a clear in the same cycle
      if (expire)     to_q <= 1'b1;
      else if (clr_i) to_q <= 1'b0;
    end
  end

  assign cnt_o     = cnt_q;
  assign run_o     = run_q;
  assign timeout_o = to_q;

  AST_DECREMENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && !expire |=> cnt_q == $past(cnt_q) - ONE) else $error("count step"); // R2
  AST_EXPIRE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> to_q) else $error("expiry lost"); // R2
  AST_CONT_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire && cont_i && !stop_i |=> run_q) else $error("continuous halted"); // R3
  AST_ONESHOT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire && !cont_i && !start_i |=> !run_q) else $error("one-shot kept running"); // R4
  AST_STOP_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !run_q) else $error("stop ignored"); // R5
  AST_CLR_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !expire |=> !to_q) else $error("clear ignored"); // R6
endmodule

// File: rtl/itmr_snap.sv
module itmr_snap #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] snap_o
);
  logic [CNT_W-1:0] snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    snap_q <= '0;
    else if (cap_i) snap_q <= cnt_i;
  end

  assign snap_o = snap_q;

  AST_SNAP_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> snap_q == $past(cnt_i)) else $error("snapshot value"); // R8
  AST_SNAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(snap_q)) else $error("snapshot drifted"); // R8
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import itmr_pkg::*;
#(
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned HALF_W = 16,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              irq_o
);
  localparam int unsigned CNT_W = 2 * HALF_W;

  ctrl_t ctrl;
  logic [CNT_W-1:0] per, per_next, cnt, snap;
  logic per_wr, start, stop, clr, cap, run, timeout;

  itmr_regfile #(.BUS_W(BUS_W), .HALF_W(HALF_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
    .run_i(run), .timeout_i(timeout), .snap_i(snap),
    .ctrl_o(ctrl), .per_o(per), .per_next_o(per_next), .per_wr_o(per_wr),
    .start_o(start), .stop_o(stop), .clr_o(clr), .cap_o(cap)
  );

  itmr_core #(.CNT_W(CNT_W)) u_core (
    .clk_i, .rst_ni, .cont_i(ctrl.cont), .start_i(start), .stop_i(stop),
    .clr_i(clr), .load_i(per_wr), .load_val_i(per_next), .reload_val_i(per),
    .cnt_o(cnt), .run_o(run), .timeout_o(timeout)
  );

  itmr_snap #(.CNT_W(CNT_W)) u_snap (
    .clk_i, .rst_ni, .cap_i(cap), .cnt_i(cnt), .snap_o(snap)
  );

  assign irq_o = timeout && ctrl.ien;

  AST_IRQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i == ADDR_W'(OFS_STATUS) && !(run && cnt == '0) |=> !irq_o)
    else $error("irq not cleared"); // R7
endmodule

// File: tb/interval_timer_tb.sv
module interval_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BUS_W = 16;
  localparam int HALF_W = 8;
  localparam int ADDR_W = 3;
  localparam int CNT_W = 2 * HALF_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [BUS_W-1:0] wdata = '0;
  logic [BUS_W-1:0] rdata;
  logic irq;

  int n_tests = 0;
  int n_fail = 0;

  // reference model state
  logic [CNT_W-1:0] m_cnt, m_per, m_snap;
  logic m_run, m_to, m_ien, m_cont;

  always #(CLK_PERIOD/2) clk = ~clk;

  interval_timer #(.BUS_W(BUS_W), .HALF_W(HALF_W), .ADDR_W(ADDR_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  always @(posedge clk or negedge rst_n) begin
    logic expire, nrun, nto;
    logic [CNT_W-1:0] ncnt, nper;
    if (!rst_n) begin
      m_cnt = '0; m_per = '0; m_snap = '0;
      m_run = 0; m_to = 0; m_ien = 0; m_cont = 0;
    end else begin
      expire = m_run && (m_cnt == 0);
      ncnt = m_cnt; nrun = m_run; nto = m_to; nper = m_per;
      if (m_run) ncnt = expire ? m_per : m_cnt - 1'b1;
      if (expire) begin nto = 1; if (!m_cont) nrun = 0; end
      if (wr) begin
        case (addr)
          3'd0: if (!expire) nto = 0;
          3'd1: if (wdata[3]) nrun = 0; else if (wdata[2]) nrun = 1;
          3'd2: nper[HALF_W-1:0] = wdata[HALF_W-1:0];
          3'd3: nper[CNT_W-1:HALF_W] = wdata[HALF_W-1:0];
          3'd4: m_snap = m_cnt;
          default: ;
        endcase
        if (!m_run && (addr == 3'd2 || addr == 3'd3)) ncnt = nper;
        if (addr == 3'd1) begin m_ien = wdata[0]; m_cont = wdata[1]; end
      end
      m_cnt = ncnt; m_run = nrun; m_to = nto; m_per = nper;
    end
  end

  function automatic logic [BUS_W-1:0] model_read(input logic [ADDR_W-1:0] a);
    logic [BUS_W-1:0] r = '0;
    case (a)
      3'd0: r[1:0] = {m_run, m_to};
      3'd1: r[1:0] = {m_cont, m_ien};
      3'd2: r[HALF_W-1:0] = m_per[HALF_W-1:0];
      3'd3: r[HALF_W-1:0] = m_per[CNT_W-1:HALF_W];
      3'd4: r[HALF_W-1:0] = m_snap[HALF_W-1:0];
      3'd5: r[HALF_W-1:0] = m_snap[CNT_W-1:HALF_W];
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [BUS_W-1:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic read_chk(input string req, input logic [ADDR_W-1:0] a);
    addr = a;
    #1;
    chk(req, 32'(rdata), 32'(model_read(a)));
    chk("R7 irq", 32'(irq), 32'(m_to && m_ien));
  endtask

  task automatic finish_tb;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_tb();
  end

  initial begin
    int n;
    logic [BUS_W-1:0] s_lo, s_hi;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state, R1 map incl. unmapped offsets
    for (int a = 0; a < 8; a++) begin
      addr = ADDR_W'(a); #1;
      chk("R10 reset read", 32'(rdata), 32'h0);
    end
    chk("R10 reset irq", 32'(irq), 32'h0);

    // R9 period load while stopped, R2 latency P+1
    bus_write(3'd2, 16'h0005);
    bus_write(3'd3, 16'h0000);
    read_chk("R1 per lo", 3'd2);
    bus_write(3'd1, 16'h0005);   // ien | start
    read_chk("R5 ctrl readback", 3'd1);
    chk("R5 start reads zero", 32'(rdata), 32'h1);
    n = 0;
    addr = 3'd0; #1;
    while (rdata[0] == 1'b0 && n < 50) begin @(negedge clk); #1; n++; end
    chk("R2 expiry latency", n, 6);
    chk("R4 one-shot halted", 32'(rdata[1]), 32'h0);
    chk("R7 irq on timeout", 32'(irq), 32'h1);
    bus_write(3'd0, 16'hbeef);
    read_chk("R6 status clear", 3'd0);
    chk("R6 flag low", 32'(rdata[0]), 32'h0);

    // R3 continuous, irq masked
    bus_write(3'd1, 16'h0006);
    repeat (20) begin @(negedge clk); read_chk("R3 continuous status", 3'd0); end
    chk("R3 still running", 32'(rdata[1]), 32'h1);
    chk("R7 masked irq", 32'(irq), 32'h0);

    // R8 snapshot consistency, high-offset write ignored
    bus_write(3'd4, 16'h0);
    read_chk("R8 snap lo", 3'd4); s_lo = rdata;
    read_chk("R8 snap hi", 3'd5); s_hi = rdata;
    bus_write(3'd5, 16'h00ff);
    repeat (3) @(negedge clk);
    read_chk("R8 snap hold", 3'd4);
    chk("R8 snap unchanged", 32'(rdata), 32'(s_lo));

    // R5 stop beats start
    bus_write(3'd1, 16'h000e);
    read_chk("R5 stop priority", 3'd0);
    chk("R5 not running", 32'(rdata[1]), 32'h0);
    chk("R8 snap hi kept", 32'(model_read(3'd5)), 32'(s_hi));

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int op;
      logic [ADDR_W-1:0] a;
      logic [BUS_W-1:0] d;
      op = $urandom_range(0, 9);
      a = ADDR_W'($urandom_range(0, 7));
      d = BUS_W'($urandom);
      if (a == 3'd2) d = BUS_W'($urandom_range(0, 12));
      if (a == 3'd3) d = ($urandom_range(0, 7) == 0) ? 16'h1 : 16'h0;
      if (op < 4) bus_write(a, d);
      else if (op < 8) read_chk("R1 R2 R3 R4 R9 random read", a);
      else @(negedge clk);
    end
    finish_tb();
  end
endmodule